// File: doc/BRIEF.md
# Privileged General-Purpose Register File

This block is the integer register file of a small in-order core. It holds 32 words of 32 bits and serves two operand reads and one result write every cycle. A third read path always shows the return-address register, so the fetch unit can load it into the program counter on a routine return without taking an operand port. Reads are combinational and writes land on the rising clock edge.

Slot 0 is a constant zero: writes to it are dropped and reads of it return zero. Two slots, 26 and 27, belong to privileged software. They behave like any other register while the kernel-mode input is high. While kernel mode is low they are fenced off: reads return zero, writes are dropped, and every cycle with such an attempt raises the violation output in the next cycle.

A write that commits in the same cycle as a read of the same slot is passed straight to that read port. The operand stage therefore sees the new value without a stall. The register, the two fenced slots and the return-address slot are parameters. All ports are plain level signals with no handshake, because the file accepts an access on every cycle.

Top module: `gp_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every register to zero and clears `priv_viol`.
- R2: With `wr_en` high and a writable `wr_addr`, `wr_data` is stored at the rising edge, and later reads of that address on either operand port return it.
- R3: Register 0 always reads as zero on every port, and a write aimed at it is discarded.
- R4: When a write commits in a cycle, a read of the same nonzero address in that cycle returns `wr_data` on `rd_a`, `rd_b` and `ret_addr`.
- R5: Registers 26 and 27 read normally while `kmode` is 1. While `kmode` is 0, a read of either one returns zero.
- R6: A write to register 26 or 27 while `kmode` is 0 is suppressed, so the stored value is unchanged.
- R7: `priv_viol` is 1 in the cycle after a cycle in which `kmode` was 0 and `ra_addr` or `rb_addr` was 26 or 27, or `wr_en` was 1 with `wr_addr` 26 or 27. It is 0 after every other cycle, so each such cycle gives a one-cycle pulse.
- R8: `ret_addr` always shows register 31.
- R9: With `wr_en` low, no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| kmode | input | 1 | High while the core runs privileged code |
| ra_addr | input | 5 | Operand A read address |
| rb_addr | input | 5 | Operand B read address |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| rd_a | output | 32 | Operand A read data |
| rd_b | output | 32 | Operand B read data |
| ret_addr | output | 32 | Return-address register contents |
| priv_viol | output | 1 | One-cycle flag after a blocked access |

## Verification
The bench uses the default parameters: 32 slots of 32 bits, slots 26 and 27 fenced, and slot 31 as the return address. With these values every fenced slot and the return slot sit at fixed addresses. The vectors can then mix fenced reads, suppressed writes and same-cycle forwarding on the return path in one sequence. They also confirm each stored value later through the operand ports.

// File: rtl/gp_regfile_pkg.sv
package gp_regfile_pkg;

  // True when an address falls inside the fenced privileged window.
  function automatic logic in_window(input int addr, input int lo, input int hi);
    return (addr >= lo) && (addr <= hi);
  endfunction

endpackage

// File: rtl/gp_regfile_guard.sv
module gp_regfile_guard #(
  parameter int AW      = 5,
  parameter int PRIV_LO = 26,
  parameter int PRIV_HI = 27
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          kmode,
  input  logic [AW-1:0] ra_addr,
  input  logic [AW-1:0] rb_addr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  output logic          wr_commit,
  output logic          priv_viol
);
  import gp_regfile_pkg::*;

  logic wr_fenced, rd_fenced, viol_d;

  assign wr_fenced = in_window(int'(wr_addr), PRIV_LO, PRIV_HI);
  assign rd_fenced = in_window(int'(ra_addr), PRIV_LO, PRIV_HI)
                   | in_window(int'(rb_addr), PRIV_LO, PRIV_HI);

  // A write lands only if enabled, not to slot 0, and not fenced off.
  assign wr_commit = wr_en && (wr_addr != '0) && !(wr_fenced && !kmode);
  assign viol_d    = !kmode && (rd_fenced || (wr_en && wr_fenced));

  always_ff @(posedge clk) begin
    if (rst) priv_viol <= 1'b0;
    else     priv_viol <= viol_d;
  end

  // R6: a fenced write outside kernel mode never commits
  a_r6_no_fenced_commit: assert property (@(posedge clk) disable iff (rst)
    (!kmode && wr_fenced) |-> !wr_commit);

endmodule

// File: rtl/gp_regfile_store.sv
module gp_regfile_store #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_commit,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] regs [DEPTH]
);

  assign regs[0] = '0;

  for (genvar i = 1; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                                   regs[i] <= '0;
      else if (wr_commit && wr_addr == AW'(i))   regs[i] <= wr_data;
    end

    // R9: a slot only changes when a commit targets it
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      !(wr_commit && wr_addr == AW'(i)) |=> $stable(regs[i]));
  end

endmodule

// File: rtl/gp_regfile_rport.sv
module gp_regfile_rport #(
  parameter int WIDTH   = 32,
  parameter int DEPTH   = 32,
  parameter int AW      = 5,
  parameter int PRIV_LO = 26,
  parameter int PRIV_HI = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kmode,
  input  logic [AW-1:0]    addr,
  input  logic             wr_commit,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] regs [DEPTH],
  output logic [WIDTH-1:0] data
);
  import gp_regfile_pkg::*;

  logic blocked, is_zero, fwd;

  assign is_zero = (addr == '0);
  assign blocked = !kmode && in_window(int'(addr), PRIV_LO, PRIV_HI);
  assign fwd     = wr_commit && (wr_addr == addr);

  always_comb begin
    if (is_zero || blocked) data = '0;
    else if (fwd)           data = wr_data;
    else                    data = regs[addr];
  end

  a_r3_zero_slot: assert property (@(posedge clk) disable iff (rst)
    (addr == '0) |-> (data == '0));

  a_r5_fenced_read: assert property (@(posedge clk) disable iff (rst)
    (!kmode && int'(addr) >= PRIV_LO && int'(addr) <= PRIV_HI) |-> (data == '0));

  a_r4_forward: assert property (@(posedge clk) disable iff (rst)
    (wr_commit && wr_addr == addr && addr != '0) |-> (data == wr_data));

endmodule

// File: rtl/gp_regfile.sv
module gp_regfile #(
  parameter int WIDTH   = 32,
  parameter int DEPTH   = 32,
  parameter int PRIV_LO = 26,
  parameter int PRIV_HI = 27,
  parameter int RET_REG = 31
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     kmode,
  input  logic [$clog2(DEPTH)-1:0] ra_addr,
  input  logic [$clog2(DEPTH)-1:0] rb_addr,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [WIDTH-1:0]         wr_data,
  output logic [WIDTH-1:0]         rd_a,
  output logic [WIDTH-1:0]         rd_b,
  output logic [WIDTH-1:0]         ret_addr,
  output logic                     priv_viol
);
  localparam int AW     = $clog2(DEPTH);
  localparam int NPORTS = 3;

  logic             wr_commit;
  logic [WIDTH-1:0] regs  [DEPTH];
  logic [AW-1:0]    paddr [NPORTS];
  logic [WIDTH-1:0] pdata [NPORTS];

  gp_regfile_guard #(.AW(AW), .PRIV_LO(PRIV_LO), .PRIV_HI(PRIV_HI)) u_guard (
    .clk(clk), .rst(rst), .kmode(kmode), .ra_addr(ra_addr), .rb_addr(rb_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_commit(wr_commit), .priv_viol(priv_viol)
  );

  gp_regfile_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst(rst), .wr_commit(wr_commit), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs(regs)
  );

  assign paddr[0] = ra_addr;
  assign paddr[1] = rb_addr;
  assign paddr[2] = AW'(RET_REG);

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    gp_regfile_rport #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW),
                       .PRIV_LO(PRIV_LO), .PRIV_HI(PRIV_HI)) u_rport (
      .clk(clk), .rst(rst), .kmode(kmode), .addr(paddr[p]),
      .wr_commit(wr_commit), .wr_addr(wr_addr), .wr_data(wr_data),
      .regs(regs), .data(pdata[p])
    );
  end

  assign rd_a     = pdata[0];
  assign rd_b     = pdata[1];
  assign ret_addr = pdata[2];

  // R7: a fenced write outside kernel mode flags in the next cycle
  a_r7_flag_write: assert property (@(posedge clk) disable iff (rst)
    (!kmode && wr_en && int'(wr_addr) >= PRIV_LO && int'(wr_addr) <= PRIV_HI)
    |=> priv_viol);

  // R7: kernel mode never produces a flag
  a_r7_quiet_kernel: assert property (@(posedge clk) disable iff (rst)
    kmode |=> !priv_viol);

endmodule

// File: tb/gp_regfile_test.sv
module gp_regfile_test;
  logic        clk = 1'b0;
  logic        rst, kmode, wr_en;
  logic [4:0]  ra_addr, rb_addr, wr_addr;
  logic [31:0] wr_data, rd_a, rd_b, ret_addr;
  logic        priv_viol;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gp_regfile uut (
    .clk(clk), .rst(rst), .kmode(kmode), .ra_addr(ra_addr), .rb_addr(rb_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_a(rd_a), .rd_b(rd_b), .ret_addr(ret_addr), .priv_viol(priv_viol)
  );

  typedef struct packed {
    logic        k;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic [4:0]  aa;
    logic [4:0]  ab;
    logic [31:0] ea;
    logic [31:0] eb;
    logic [31:0] er;
    logic        ev;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b1, 5'd5,  32'hA5A5_0001, 5'd5,  5'd5,  32'hA5A5_0001, 32'hA5A5_0001, 32'h0,         1'b0}, // R2 R4
    '{1'b0, 1'b1, 5'd0,  32'hFFFF_FFFF, 5'd0,  5'd5,  32'h0,         32'hA5A5_0001, 32'h0,         1'b0}, // R3
    '{1'b0, 1'b0, 5'd6,  32'h0000_1234, 5'd6,  5'd0,  32'h0,         32'h0,         32'h0,         1'b0}, // R9 R3
    '{1'b1, 1'b1, 5'd26, 32'hC0DE_0026, 5'd26, 5'd27, 32'hC0DE_0026, 32'h0,         32'h0,         1'b0}, // R5 R4
    '{1'b0, 1'b0, 5'd0,  32'h0,         5'd26, 5'd1,  32'h0,         32'h0,         32'h0,         1'b1}, // R5 R7
    '{1'b0, 1'b1, 5'd27, 32'hBAD0_0027, 5'd3,  5'd4,  32'h0,         32'h0,         32'h0,         1'b1}, // R6 R7
    '{1'b1, 1'b0, 5'd0,  32'h0,         5'd26, 5'd27, 32'hC0DE_0026, 32'h0,         32'h0,         1'b0}, // R6 R5
    '{1'b1, 1'b1, 5'd31, 32'h8000_0100, 5'd31, 5'd5,  32'h8000_0100, 32'hA5A5_0001, 32'h8000_0100, 1'b0}, // R8 R4
    '{1'b0, 1'b0, 5'd0,  32'h0,         5'd27, 5'd31, 32'h0,         32'h8000_0100, 32'h8000_0100, 1'b1}, // R8 R7
    '{1'b0, 1'b1, 5'd7,  32'h0000_0077, 5'd2,  5'd7,  32'h0,         32'h0000_0077, 32'h8000_0100, 1'b0}, // R4
    '{1'b1, 1'b1, 5'd27, 32'h2727_2727, 5'd27, 5'd26, 32'h2727_2727, 32'hC0DE_0026, 32'h8000_0100, 1'b0}, // R5
    '{1'b0, 1'b1, 5'd26, 32'h0000_0001, 5'd26, 5'd0,  32'h0,         32'h0,         32'h8000_0100, 1'b1}, // R6 R7
    '{1'b1, 1'b0, 5'd0,  32'h0,         5'd26, 5'd27, 32'hC0DE_0026, 32'h2727_2727, 32'h8000_0100, 1'b0}  // R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic k, input logic we, input logic [4:0] wa,
                       input logic [31:0] wd, input logic [4:0] aa, input logic [4:0] ab);
    kmode = k; wr_en = we; wr_addr = wa; wr_data = wd; ra_addr = aa; rb_addr = ab;
  endtask

  initial begin
    rst = 1'b1;
    drive(1'b1, 1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    drive(1'b1, 1'b0, 5'd0, 32'h0, 5'd26, 5'd31);
    #2;
    check("R1 rd_a", rd_a, 32'h0);
    check("R1 rd_b", rd_b, 32'h0);
    check("R1 viol", {31'h0, priv_viol}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i].k, TBL[i].we, TBL[i].wa, TBL[i].wd, TBL[i].aa, TBL[i].ab);
      #2;
      check($sformatf("R2/R4/R5 rd_a vec %0d", i), rd_a, TBL[i].ea);
      check($sformatf("R2/R4/R5 rd_b vec %0d", i), rd_b, TBL[i].eb);
      check($sformatf("R8 ret_addr vec %0d", i), ret_addr, TBL[i].er);
      @(posedge clk);
      #1;
      check($sformatf("R7 priv_viol vec %0d", i), {31'h0, priv_viol}, {31'h0, TBL[i].ev});
    end

    // R3: slot 0 stays zero on both ports after a write attempt
    @(negedge clk);
    drive(1'b1, 1'b1, 5'd0, 32'h5555_5555, 5'd0, 5'd0);
    @(negedge clk);
    drive(1'b1, 1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
    #2;
    check("R3 rd_a slot0", rd_a, 32'h0);
    check("R3 rd_b slot0", rd_b, 32'h0);

    // R1: reset in mid-run with a fenced access in the same cycle
    @(negedge clk);
    rst = 1'b1;
    drive(1'b0, 1'b0, 5'd0, 32'h0, 5'd26, 5'd0);
    @(posedge clk);
    #1;
    check("R1 viol cleared", {31'h0, priv_viol}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    drive(1'b1, 1'b0, 5'd0, 32'h0, 5'd5, 5'd26);
    #2;
    check("R1 slot5 cleared", rd_a, 32'h0);
    check("R1 slot26 cleared", rd_b, 32'h0);
    check("R1 slot31 cleared", ret_addr, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule